// File: doc/BRIEF.md
# Grouped Interrupt Combiner

This block gathers level-sensitive interrupt inputs into groups of eight and raises one combined request per group toward a parent interrupt controller. Each group also reports whether any of its enabled inputs is pending, and which pending enabled input has the lowest number. The dispatcher can then service that input without scanning the status word.

Software reaches the block through a plain 32-bit register bus with separate write and read strobes. The read data is registered and arrives, with a valid flag, in the cycle after the read strobe. Registers sit in 16-byte banks. A bank serves four neighbouring groups, one per byte lane. Within a bank, enables can only be turned on through one register and turned off through another, so two agents can change different sources without a read-modify-write.

Top module: `irq_group_combiner`

## Requirements
- R1: After a synchronous reset every enable bit is 0, and every group request, valid flag and index is 0. Reads of every implemented register then return 0.
- R2: A write to bank offset 0x0 sets each enable bit whose write-data bit is 1. Enable bits whose write-data bit is 0 keep their value.
- R3: A write to bank offset 0x4 clears each enable bit whose write-data bit is 1. Enable bits whose write-data bit is 0 keep their value.
- R4: Reads of bank offset 0x0 and of bank offset 0x4 both return the bank's current 32 enable bits.
- R5: A read of bank offset 0xC returns, for each source, its input level ANDed with its enable bit. Group n uses the bank at byte address 0x10*(n/4), in bits 8*(n mod 4)+7 down to 8*(n mod 4). Source j of group n is input bit 8n+j.
- R6: The request of group n is high one cycle after any of its enabled inputs is high. It stays high while such an input stays high, and it falls one cycle after the last one drops.
- R7: The valid flag of group n equals its request. The 3-bit index of group n gives the lowest-numbered enabled pending source of that group, and reads 0 when none is pending.
- R8: Writes to bank offset 0x8, or to a bank beyond the last implemented group, change no enable bit. Reads of those addresses return 0.
- R9: The read data and its valid flag are registered. Valid is high exactly in the cycle after a read strobe, and the read data is 0 in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| src_level | input | NUM_GROUPS*8 | Level interrupt inputs, source j of group n at bit 8n+j |
| grp_req | output | NUM_GROUPS | Combined request per group |
| grp_valid | output | NUM_GROUPS | Per-group pending flag |
| grp_idx | output | NUM_GROUPS*3 | Lowest pending enabled source per group, group n at bits 3n+2:3n |

## Verification
The enable storage is driven with overlapping set and clear words, so that a lost OR or AND-NOT shows up as a wrong readback. Input patterns place single sources at both ends of a group (bit 0 and bit 7). Others put several sources in one group, so the lowest-index search is told apart from a highest-index search. Some patterns set a source whose enable is off; these separate masked status from raw input. Patterns spread across the four byte lanes and both banks catch a shifted lane or bank decode. Dropping the inputs shows that the requests follow the level and do not latch.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int SRC_PER_GRP  = 8;
  localparam int GRP_PER_BANK = 4;
  localparam int BANK_BITS    = 32;

  typedef enum logic [1:0] {
    OFF_EN_SET = 2'd0,
    OFF_EN_CLR = 2'd1,
    OFF_SPARE  = 2'd2,
    OFF_STATUS = 2'd3
  } reg_off_e;

  // Byte lanes of a bank that carry a real group.
  function automatic logic [BANK_BITS-1:0] lane_mask(input int bank, input int groups);
    logic [BANK_BITS-1:0] m;
    m = '0;
    for (int l = 0; l < GRP_PER_BANK; l++) begin
      if (bank * GRP_PER_BANK + l < groups) m[l*SRC_PER_GRP +: SRC_PER_GRP] = 8'hFF;
    end
    return m;
  endfunction

  function automatic logic [2:0] lowest_idx(input logic [SRC_PER_GRP-1:0] v);
    logic [2:0] idx;
    idx = 3'd0;
    for (int i = SRC_PER_GRP - 1; i >= 0; i--) begin
      if (v[i]) idx = 3'(i);
    end
    return idx;
  endfunction

endpackage

// File: rtl/irqc_addr_decode.sv
module irqc_addr_decode
  import irqc_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_BANKS = 2
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wr,
  output logic [NUM_BANKS-1:0] bank_sel,
  output logic [NUM_BANKS-1:0] set_stb,
  output logic [NUM_BANKS-1:0] clr_stb,
  output reg_off_e             off
);

  localparam int BANK_W = ADDR_W - 4;

  logic [BANK_W-1:0] bank_idx;

  assign bank_idx = addr[ADDR_W-1:4];
  assign off      = reg_off_e'(addr[3:2]);

  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      bank_sel[b] = (int'(bank_idx) == b);
      set_stb[b]  = wr && bank_sel[b] && (off == OFF_EN_SET);
      clr_stb[b]  = wr && bank_sel[b] && (off == OFF_EN_CLR);
    end
  end

endmodule

// File: rtl/irqc_enable_bank.sv
module irqc_enable_bank
  import irqc_pkg::*;
#(
  parameter int BANK       = 0,
  parameter int NUM_GROUPS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 set_stb,
  input  logic                 clr_stb,
  input  logic [BANK_BITS-1:0] wdata,
  output logic [BANK_BITS-1:0] en
);

  localparam logic [BANK_BITS-1:0] MASK = lane_mask(BANK, NUM_GROUPS);

  always_ff @(posedge clk) begin
    if (rst) begin
      en <= '0;
    end else if (set_stb) begin
      en <= en | (wdata & MASK);
    end else if (clr_stb) begin
      en <= en & ~(wdata & MASK);
    end
  end

endmodule

// File: rtl/irqc_group_out.sv
module irqc_group_out
  import irqc_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic [SRC_PER_GRP-1:0] pend,
  output logic                   req,
  output logic                   valid,
  output logic [2:0]             idx
);

  always_ff @(posedge clk) begin
    if (rst) begin
      req   <= 1'b0;
      valid <= 1'b0;
      idx   <= 3'd0;
    end else begin
      req   <= |pend;
      valid <= |pend;
      idx   <= lowest_idx(pend);
    end
  end

endmodule

// File: rtl/irq_group_combiner.sv
module irq_group_combiner
  import irqc_pkg::*;
#(
  parameter int NUM_GROUPS = 8,
  parameter int ADDR_W     = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              bus_wr,
  input  logic                              bus_rd,
  input  logic [ADDR_W-1:0]                 bus_addr,
  input  logic [31:0]                       bus_wdata,
  output logic [31:0]                       bus_rdata,
  output logic                              bus_rvalid,
  input  logic [NUM_GROUPS*SRC_PER_GRP-1:0] src_level,
  output logic [NUM_GROUPS-1:0]             grp_req,
  output logic [NUM_GROUPS-1:0]             grp_valid,
  output logic [NUM_GROUPS*3-1:0]           grp_idx
);

  localparam int NUM_SRC   = NUM_GROUPS * SRC_PER_GRP;
  localparam int NUM_BANKS = (NUM_GROUPS + GRP_PER_BANK - 1) / GRP_PER_BANK;
  localparam int FLAT_W    = NUM_BANKS * BANK_BITS;

  logic [NUM_BANKS-1:0] bank_sel, set_stb, clr_stb;
  reg_off_e             off;
  logic [FLAT_W-1:0]    en_all;
  logic [FLAT_W-1:0]    src_pad;
  logic [FLAT_W-1:0]    stat_all;
  logic [31:0]          rd_mux;

  irqc_addr_decode #(
    .ADDR_W   (ADDR_W),
    .NUM_BANKS(NUM_BANKS)
  ) u_dec (
    .addr    (bus_addr),
    .wr      (bus_wr),
    .bank_sel(bank_sel),
    .set_stb (set_stb),
    .clr_stb (clr_stb),
    .off     (off)
  );

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      irqc_enable_bank #(
        .BANK      (b),
        .NUM_GROUPS(NUM_GROUPS)
      ) u_en (
        .clk    (clk),
        .rst    (rst),
        .set_stb(set_stb[b]),
        .clr_stb(clr_stb[b]),
        .wdata  (bus_wdata),
        .en     (en_all[b*BANK_BITS +: BANK_BITS])
      );
    end

    if (FLAT_W > NUM_SRC) begin : g_pad
      assign src_pad = {{(FLAT_W-NUM_SRC){1'b0}}, src_level};
    end else begin : g_nopad
      assign src_pad = src_level;
    end
  endgenerate

  assign stat_all = en_all & src_pad;

  generate
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      irqc_group_out u_out (
        .clk  (clk),
        .rst  (rst),
        .pend (stat_all[g*SRC_PER_GRP +: SRC_PER_GRP]),
        .req  (grp_req[g]),
        .valid(grp_valid[g]),
        .idx  (grp_idx[g*3 +: 3])
      );
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_sel[b]) begin
        unique case (off)
          OFF_EN_SET, OFF_EN_CLR: rd_mux = en_all[b*BANK_BITS +: BANK_BITS];
          OFF_STATUS:             rd_mux = stat_all[b*BANK_BITS +: BANK_BITS];
          default:                rd_mux = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      bus_rdata  <= bus_rd ? rd_mux : '0;
    end
  end

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
#(
  parameter int NUM_GROUPS = 8,
  parameter int ADDR_W     = 8
) (
  input logic                                   clk,
  input logic                                   rst,
  input logic                                   bus_wr,
  input logic                                   bus_rd,
  input logic [ADDR_W-1:0]                      bus_addr,
  input logic [31:0]                            bus_wdata,
  input logic [31:0]                            bus_rdata,
  input logic                                   bus_rvalid,
  input logic [NUM_GROUPS*SRC_PER_GRP-1:0]      src_level,
  input logic [NUM_GROUPS-1:0]                  grp_req,
  input logic [NUM_GROUPS-1:0]                  grp_valid,
  input logic [NUM_GROUPS*3-1:0]                grp_idx,
  input logic [((NUM_GROUPS+3)/4)*BANK_BITS-1:0] en_all
);

  localparam int NUM_BANKS = (NUM_GROUPS + 3) / 4;
  localparam int NUM_SRC   = NUM_GROUPS * SRC_PER_GRP;

  logic [NUM_SRC-1:0]                src_q;
  logic [NUM_BANKS*BANK_BITS-1:0]    en_q;

  always_ff @(posedge clk) begin
    src_q <= src_level;
    en_q  <= en_all;
  end

  // R9
  rvalid_follows_rd_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);

  // R9
  rdata_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (!bus_rvalid && bus_rdata == 32'd0));

  // R8
  spare_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr[3:2] == 2'd2) |=> $stable(en_all));

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bchk
      localparam logic [31:0] M = lane_mask(b, NUM_GROUPS);

      // R2
      set_bits_land_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && int'(bus_addr[ADDR_W-1:4]) == b && bus_addr[3:2] == 2'd0)
        |=> ((en_all[b*32 +: 32] & $past(bus_wdata) & M) == ($past(bus_wdata) & M)));

      // R3
      clr_bits_land_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && int'(bus_addr[ADDR_W-1:4]) == b && bus_addr[3:2] == 2'd1)
        |=> ((en_all[b*32 +: 32] & $past(bus_wdata) & M) == 32'd0));
    end

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_gchk
      localparam int EB = (g / 4) * 32 + (g % 4) * 8;

      // R6
      req_tracks_level_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (grp_req[g] == |(src_q[g*8 +: 8] & en_q[EB +: 8])));

      // R7
      valid_equals_req_chk: assert property (@(posedge clk) disable iff (rst)
        grp_valid[g] == grp_req[g]);

      // R7
      idx_is_lowest_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && grp_valid[g]) |->
          (((src_q[g*8 +: 8] & en_q[EB +: 8]) >> grp_idx[g*3 +: 3]) & 8'd1) == 8'd1 &&
          ((src_q[g*8 +: 8] & en_q[EB +: 8] & ((8'd1 << grp_idx[g*3 +: 3]) - 8'd1)) == 8'd0));
    end
  endgenerate

endmodule

bind irq_group_combiner irqc_checker #(
  .NUM_GROUPS(NUM_GROUPS),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .bus_rvalid(bus_rvalid),
  .src_level (src_level),
  .grp_req   (grp_req),
  .grp_valid (grp_valid),
  .grp_idx   (grp_idx),
  .en_all    (en_all)
);

// File: tb/irq_group_combiner_bench.sv
module irq_group_combiner_bench;

  localparam int NG  = 8;
  localparam int AW  = 8;
  localparam int NB  = (NG + 3) / 4;
  localparam int NS  = NG * 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            bus_wr = 1'b0;
  logic            bus_rd = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic            bus_rvalid;
  logic [NS-1:0]   src_level = '0;
  logic [NG-1:0]   grp_req;
  logic [NG-1:0]   grp_valid;
  logic [NG*3-1:0] grp_idx;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  irq_group_combiner #(.NUM_GROUPS(NG), .ADDR_W(AW)) u_irq_group_combiner (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .src_level(src_level), .grp_req(grp_req), .grp_valid(grp_valid), .grp_idx(grp_idx)
  );

  // Bench model of the enable bits.
  logic [31:0] m_en [NB];

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } rd_item_t;
  rd_item_t sb_q[$];

  function automatic logic [31:0] exp_read(input logic [AW-1:0] a);
    int bk;
    bk = int'(a[AW-1:4]);
    if (bk >= NB) return 32'd0;
    case (a[3:2])
      2'd0, 2'd1: return m_en[bk];
      2'd3:       return m_en[bk] & src_level[bk*32 +: 32];
      default:    return 32'd0;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    int bk;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    bk = int'(a[AW-1:4]);
    if (bk < NB) begin
      if (a[3:2] == 2'd0) m_en[bk] = m_en[bk] | d;
      else if (a[3:2] == 2'd1) m_en[bk] = m_en[bk] & ~d;
    end
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, input string tag);
    rd_item_t it;
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    it.exp = exp_read(a);
    it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // Monitor: pops one expected item per valid read beat.
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R9 unexpected rvalid", 32'd1, 32'd0);
      end else begin
        rd_item_t it;
        it = sb_q.pop_front();
        check(bus_rdata === it.exp, it.tag, bus_rdata, it.exp);
      end
    end
  end

  function automatic logic [2:0] low_bit(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return 3'(i);
    return 3'd0;
  endfunction

  task automatic check_groups(input string tag);
    repeat (2) @(posedge clk);
    @(negedge clk);
    for (int g = 0; g < NG; g++) begin
      logic [7:0]  st;
      logic [31:0] act, exp;
      st  = m_en[g/4][(g%4)*8 +: 8] & src_level[g*8 +: 8];
      exp = {27'd0, |st, |st, low_bit(st)};
      act = {27'd0, grp_req[g], grp_valid[g], grp_idx[g*3 +: 3]};
      check(act === exp, $sformatf("%s group %0d", tag, g), act, exp);
    end
  endtask

  initial begin
    for (int b = 0; b < NB; b++) m_en[b] = 32'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check_groups("R1 reset outputs");
    bus_read(8'h00, "R1 reset enable bank0");
    bus_read(8'h14, "R1 reset enable bank1");
    bus_read(8'h0C, "R1 reset status bank0");

    // R2/R4: set and read back through both offsets
    bus_write(8'h00, 32'h0000_0F05);
    bus_write(8'h00, 32'h0000_0100);
    bus_read(8'h00, "R2 set accumulates");
    bus_read(8'h04, "R4 read via clear offset");

    // R3: clear only the written ones
    bus_write(8'h04, 32'h0000_0004);
    bus_read(8'h00, "R3 clear one bit");

    // R5/R6/R7: group 0 with masked inputs
    src_level[7:0] = 8'h06;
    bus_read(8'h0C, "R5 masked status group0");
    check_groups("R6 group0 partial enable");
    src_level[15:8] = 8'h0C;
    check_groups("R7 group1 lowest");

    // R5: bank 1 lanes, group 4 and group 7
    bus_write(8'h10, 32'hFF00_0080);
    src_level[39:32] = 8'h80;
    src_level[63:56] = 8'hA8;
    bus_read(8'h1C, "R5 status bank1 lanes");
    check_groups("R7 top bit and multi-source");
    src_level[63:56] = 8'h01;
    check_groups("R7 bit0 of group7");

    // R6: level drop
    src_level = '0;
    check_groups("R6 requests fall with level");
    bus_read(8'h1C, "R5 status cleared");

    // R8: spare offset and out of range bank
    bus_write(8'h08, 32'hFFFF_FFFF);
    bus_write(8'h18, 32'hFFFF_FFFF);
    bus_write(8'h20, 32'hFFFF_FFFF);
    bus_write(8'h24, 32'hFFFF_FFFF);
    bus_read(8'h00, "R8 bank0 untouched");
    bus_read(8'h10, "R8 bank1 untouched");
    bus_read(8'h08, "R8 spare reads zero");
    bus_read(8'h20, "R8 out of range reads zero");

    // R2: set lane 2 of bank 0 then drive group 2
    bus_write(8'h00, 32'h00FF_0000);
    src_level[23:16] = 8'h30;
    check_groups("R2 group2 enabled");

    // R9: idle cycle has no valid and zero data
    @(negedge clk);
    check(bus_rvalid === 1'b0 && bus_rdata === 32'd0, "R9 idle read port",
          {bus_rvalid, bus_rdata[30:0]}, 32'd0);

    repeat (3) @(negedge clk);
    check(sb_q.size() == 0, "R9 all reads returned", sb_q.size(), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 32'd1, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule